// File: doc/BRIEF.md
# Key Slot Access Guard

This block sits between the software register bus of a cipher engine and the two things software must not reach freely: the key store and the cipher core. It holds an access permission pair for each of four general key slots plus one dedicated secure slot. It also holds the active slot index, a switch that turns off hardware key-schedule generation, and an engine kill bit.

The permission bits are one-way locks. After reset every slot can be read and updated. Software can clear either right, but it can never set it again until the next reset. The kill bit behaves the other way round: once software sets it, it stays set, and any later start request to the cipher is swallowed and recorded in a sticky error flag.

Key traffic passes through the guard combinationally. Writes toward the key store are dropped when the target slot has lost its update right. Data read back from a slot that has lost its read right is forced to zero. Both rules apply to key words and IV words alike.

Top module: `kslot_guard`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0, the slot index (0x04) reads 0, the extended configuration (0x08) reads 0, and every select register reads 0x3. No start reaches the core.
- R2: Each select register sits at 0x10 + 4*code and has the read right in bit 0. Writing 0 to bit 0 clears the right. A later write with bit 0 set leaves it cleared.
- R3: In the same select register, bit 1 is the update right. It can be cleared by a write and never set again by one.
- R4: A key read (kr_slot) from a slot whose read right is set returns ks_rd_data unchanged. When the read right is cleared, kr_data is 0.
- R5: A key write (kw_valid) to a slot whose update right is set raises ks_we and passes the slot, word and data through. When the update right is cleared, ks_we stays 0.
- R6: Slot code 4 is the dedicated secure slot. Its select register at 0x20 locks independently of slots 0 to 3.
- R7: Writing 1 to bit 0 of the control word disables the engine. A later write of 0 leaves the word reading 0x1, and eng_off stays high.
- R8: While the engine is disabled, core_start stays 0. A start request in that state sets err_flag, which also reads as control bit 1, and the flag stays set until reset.
- R9: Bits [1:0] of 0x04 set act_slot, and upper bits of that write are discarded. Bit 0 of 0x08 drives sched_off. Both can be rewritten freely.
- R10: Slot codes 5 to 7 are invalid. Key reads from them return 0 and key writes to them are dropped.
- R11: Unmapped or unaligned offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| kw_valid | input | 1 | Key write request |
| kw_slot | input | 3 | Key write slot code |
| kw_word | input | 2 | Key write word index |
| kw_data | input | 32 | Key write data |
| ks_we | output | 1 | Gated write enable to key store |
| ks_slot | output | 3 | Slot code to key store |
| ks_word | output | 2 | Word index to key store |
| ks_wdata | output | 32 | Write data to key store |
| kr_slot | input | 3 | Slot code of current key read |
| ks_rd_data | input | 32 | Raw data from key store |
| kr_data | output | 32 | Masked read data |
| start_req | input | 1 | Start request toward cipher |
| core_start | output | 1 | Gated start to cipher core |
| err_flag | output | 1 | Sticky start-while-disabled error |
| act_slot | output | 2 | Active slot index |
| sched_off | output | 1 | Key-schedule generation disabled |
| eng_off | output | 1 | Engine disabled |

## Verification
The bench builds the guard with its default parameters: four general slots, four key words, an 8-bit offset and 32-bit data. With these values the slot code is 3 bits wide, so the bench can drive the secure slot (code 4) and all three invalid codes (5 to 7) through the key ports. The first offset past the select bank, 0x24, is also reachable and is checked as unmapped. The 2-bit index lets a write of all ones show that the upper bits of the index write are discarded.

// File: rtl/kslot_pkg.sv
package kslot_pkg;

    localparam int REG_W     = 32;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CFG   = 'h04;
    localparam int OFF_EXT   = 'h08;
    localparam int SEL_BASE  = 'h10;
    localparam int SEL_STEP  = 4;

    // bit 1: update right, bit 0: read right
    typedef struct packed {
        logic upd_en;
        logic rd_en;
    } perm_t;

    localparam perm_t PERM_OPEN = '{upd_en: 1'b1, rd_en: 1'b1};

    // rights can only be removed by a write
    function automatic perm_t perm_after_write(input perm_t cur, input logic [1:0] wbits);
        return perm_t'({cur.upd_en & wbits[1], cur.rd_en & wbits[0]});
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(input logic off, input logic err);
        logic [REG_W-1:0] w;
        w    = '0;
        w[0] = off;
        w[1] = err;
        return w;
    endfunction

endpackage

// File: rtl/kslot_perm_bank.sv
module kslot_perm_bank
    import kslot_pkg::*;
#(
    parameter int N_SEL  = 5,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wbits,
    output logic [N_SEL-1:0]  rd_en,
    output logic [N_SEL-1:0]  upd_en,
    output logic              hit,
    output logic [1:0]        rbits
);

    logic [N_SEL-1:0] hit_vec;

    for (genvar i = 0; i < N_SEL; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(SEL_BASE + SEL_STEP * i);
        perm_t p_q;

        assign hit_vec[i] = (addr == MY_OFF);

        always_ff @(posedge clk) begin
            if (rst) begin
                p_q <= PERM_OPEN;
            end else if (wr_en && hit_vec[i]) begin
                p_q <= perm_after_write(p_q, wbits);
            end
        end

        assign rd_en[i]  = p_q.rd_en;
        assign upd_en[i] = p_q.upd_en;

        p_rd_one_way_r2: assert property (@(posedge clk) disable iff (rst)
            !$rose(p_q.rd_en));
        p_upd_one_way_r3: assert property (@(posedge clk) disable iff (rst)
            !$rose(p_q.upd_en));
    end

    always_comb begin
        rbits = 2'b00;
        for (int i = 0; i < N_SEL; i++) begin
            if (hit_vec[i]) begin
                rbits = rbits | {upd_en[i], rd_en[i]};
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/kslot_ctrl_regs.sv
module kslot_ctrl_regs
    import kslot_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  wdata,
    input  logic              start_req,
    output logic              eng_off,
    output logic              err,
    output logic [IDX_W-1:0]  act_idx,
    output logic              sched_off,
    output logic              core_start,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(OFF_EXT);

    logic             off_q, err_q, sched_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_ctrl, wr_cfg, wr_ext;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_cfg  = wr_en && (addr == A_CFG);
    assign wr_ext  = wr_en && (addr == A_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= 1'b0;
            err_q   <= 1'b0;
            sched_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (wr_ctrl && wdata[0]) off_q <= 1'b1;
            if (start_req && off_q)  err_q <= 1'b1;
            if (wr_ext)              sched_q <= wdata[0];
            if (wr_cfg)              idx_q <= wdata;
        end
    end

    assign core_start = start_req & ~off_q;
    assign eng_off    = off_q;
    assign err        = err_q;
    assign act_idx    = idx_q;
    assign sched_off  = sched_q;

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)      rdata = ctrl_word(off_q, err_q);
        else if (addr == A_CFG)  rdata = REG_W'(idx_q);
        else if (addr == A_EXT)  rdata = REG_W'(sched_q);
    end

    p_off_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        off_q |=> off_q);
    p_start_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        off_q |-> !core_start);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !err_q ##1 err_q |-> $past(start_req && off_q));
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(idx_q));

endmodule

// File: rtl/kslot_access_gate.sv
module kslot_access_gate #(
    parameter int N_SEL  = 5,
    parameter int SLOT_W = 3,
    parameter int KW_W   = 2,
    parameter int KEY_W  = 32
) (
    input  logic [N_SEL-1:0]  rd_en,
    input  logic [N_SEL-1:0]  upd_en,
    input  logic              kw_valid,
    input  logic [SLOT_W-1:0] kw_slot,
    input  logic [KW_W-1:0]   kw_word,
    input  logic [KEY_W-1:0]  kw_data,
    input  logic [SLOT_W-1:0] kr_slot,
    input  logic [KEY_W-1:0]  ks_rd_data,
    output logic              ks_we,
    output logic [SLOT_W-1:0] ks_slot,
    output logic [KW_W-1:0]   ks_word,
    output logic [KEY_W-1:0]  ks_wdata,
    output logic [KEY_W-1:0]  kr_data
);

    logic rd_ok, wr_ok;

    // codes outside the bank match no entry and stay blocked
    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        for (int i = 0; i < N_SEL; i++) begin
            if (kr_slot == SLOT_W'(i)) rd_ok = rd_en[i];
            if (kw_slot == SLOT_W'(i)) wr_ok = upd_en[i];
        end
    end

    assign ks_we    = kw_valid & wr_ok;
    assign ks_slot  = kw_slot;
    assign ks_word  = kw_word;
    assign ks_wdata = kw_data;
    assign kr_data  = rd_ok ? ks_rd_data : '0;

endmodule

// File: rtl/kslot_guard.sv
module kslot_guard
    import kslot_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int KEY_WORDS = 4,
    parameter int ADDR_W    = 8,
    parameter int KEY_W     = 32,
    localparam int N_SEL    = NUM_SLOTS + 1,
    localparam int SLOT_W   = $clog2(N_SEL),
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int KW_W     = $clog2(KEY_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              kw_valid,
    input  logic [SLOT_W-1:0] kw_slot,
    input  logic [KW_W-1:0]   kw_word,
    input  logic [KEY_W-1:0]  kw_data,
    output logic              ks_we,
    output logic [SLOT_W-1:0] ks_slot,
    output logic [KW_W-1:0]   ks_word,
    output logic [KEY_W-1:0]  ks_wdata,
    input  logic [SLOT_W-1:0] kr_slot,
    input  logic [KEY_W-1:0]  ks_rd_data,
    output logic [KEY_W-1:0]  kr_data,
    input  logic              start_req,
    output logic              core_start,
    output logic              err_flag,
    output logic [IDX_W-1:0]  act_slot,
    output logic              sched_off,
    output logic              eng_off
);

    localparam int N_CODE = 1 << SLOT_W;

    logic [N_SEL-1:0] rd_en, upd_en;
    logic             bank_hit;
    logic [1:0]       bank_rbits;
    logic [REG_W-1:0] ctrl_rdata;

    kslot_perm_bank #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wbits  (reg_wdata[1:0]),
        .rd_en  (rd_en),
        .upd_en (upd_en),
        .hit    (bank_hit),
        .rbits  (bank_rbits)
    );

    kslot_ctrl_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata[IDX_W-1:0]),
        .start_req  (start_req),
        .eng_off    (eng_off),
        .err        (err_flag),
        .act_idx    (act_slot),
        .sched_off  (sched_off),
        .core_start (core_start),
        .rdata      (ctrl_rdata)
    );

    kslot_access_gate #(.N_SEL(N_SEL), .SLOT_W(SLOT_W), .KW_W(KW_W), .KEY_W(KEY_W)) u_gate (
        .rd_en      (rd_en),
        .upd_en     (upd_en),
        .kw_valid   (kw_valid),
        .kw_slot    (kw_slot),
        .kw_word    (kw_word),
        .kw_data    (kw_data),
        .kr_slot    (kr_slot),
        .ks_rd_data (ks_rd_data),
        .ks_we      (ks_we),
        .ks_slot    (ks_slot),
        .ks_word    (ks_word),
        .ks_wdata   (ks_wdata),
        .kr_data    (kr_data)
    );

    assign reg_rdata = bank_hit ? REG_W'(bank_rbits) : ctrl_rdata;

    logic [N_CODE-1:0] rd_pad, upd_pad;
    assign rd_pad  = N_CODE'(rd_en);
    assign upd_pad = N_CODE'(upd_en);

    p_we_needs_right_r5: assert property (@(posedge clk) disable iff (rst)
        ks_we |-> upd_pad[kw_slot]);
    p_read_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (kr_data != '0) |-> rd_pad[kr_slot]);
    p_bad_code_r10: assert property (@(posedge clk) disable iff (rst)
        (kw_slot >= SLOT_W'(N_SEL)) |-> !ks_we);

endmodule

// File: tb/test_kslot_guard.sv
module test_kslot_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        kw_valid;
    logic [2:0]  kw_slot, ks_slot, kr_slot;
    logic [1:0]  kw_word, ks_word, act_slot;
    logic [31:0] kw_data, ks_wdata, ks_rd_data, kr_data;
    logic        ks_we, start_req, core_start, err_flag, sched_off, eng_off;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    kslot_guard i_kslot_guard (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kw_valid(kw_valid),
        .kw_slot(kw_slot), .kw_word(kw_word), .kw_data(kw_data), .ks_we(ks_we),
        .ks_slot(ks_slot), .ks_word(ks_word), .ks_wdata(ks_wdata),
        .kr_slot(kr_slot), .ks_rd_data(ks_rd_data), .kr_data(kr_data),
        .start_req(start_req), .core_start(core_start), .err_flag(err_flag),
        .act_slot(act_slot), .sched_off(sched_off), .eng_off(eng_off)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 ctrl", 8'h00, 32'h0);
        rd_check("R1 cfg", 8'h04, 32'h0);
        rd_check("R1 ext", 8'h08, 32'h0);
        for (int i = 0; i < 5; i++) rd_check("R1 sel", 8'(8'h10 + 4 * i), 32'h3);
        start_req = 1'b0;
        #1;
        check("R1 core_start", 32'(core_start), 32'h0);
        check("R1 err_flag", 32'(err_flag), 32'h0);
    endtask

    task automatic t_read_lock;
        ks_rd_data = 32'hA5A5_1234;
        kr_slot    = 3'd1;
        #1;
        check("R4 open read", kr_data, 32'hA5A5_1234);
        wr_reg(8'h14, 32'h2);
        rd_check("R2 rd cleared", 8'h14, 32'h2);
        check("R4 masked read", kr_data, 32'h0);
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_check("R2 rd not restored", 8'h14, 32'h2);
        check("R2 still masked", kr_data, 32'h0);
        kr_slot = 3'd0;
        #1;
        check("R4 other slot open", kr_data, 32'hA5A5_1234);
    endtask

    task automatic t_update_lock;
        @(negedge clk);
        kw_valid = 1'b1; kw_slot = 3'd2; kw_word = 2'd3; kw_data = 32'hDEAD_BEEF;
        #1;
        check("R5 write passes", 32'(ks_we), 32'h1);
        check("R5 slot", 32'(ks_slot), 32'h2);
        check("R5 word", 32'(ks_word), 32'h3);
        check("R5 data", ks_wdata, 32'hDEAD_BEEF);
        wr_reg(8'h18, 32'h1);
        #1;
        check("R5 write dropped", 32'(ks_we), 32'h0);
        wr_reg(8'h18, 32'h3);
        rd_check("R3 upd not restored", 8'h18, 32'h1);
        check("R3 still dropped", 32'(ks_we), 32'h0);
        kr_slot = 3'd2;
        #1;
        check("R3 read unaffected", kr_data, 32'hA5A5_1234);
        kw_valid = 1'b0;
    endtask

    task automatic t_secure;
        wr_reg(8'h20, 32'h0);
        rd_check("R6 secure sel", 8'h20, 32'h0);
        rd_check("R6 slot3 untouched", 8'h1C, 32'h3);
        kr_slot = 3'd4;
        kw_valid = 1'b1; kw_slot = 3'd4;
        #1;
        check("R6 secure read", kr_data, 32'h0);
        check("R6 secure write", 32'(ks_we), 32'h0);
        kw_slot = 3'd3;
        #1;
        check("R6 slot3 write", 32'(ks_we), 32'h1);
        kw_valid = 1'b0;
    endtask

    task automatic t_invalid;
        kw_valid = 1'b1;
        for (int c = 5; c < 8; c++) begin
            kr_slot = 3'(c);
            kw_slot = 3'(c);
            #1;
            check("R10 bad code read", kr_data, 32'h0);
            check("R10 bad code write", 32'(ks_we), 32'h0);
        end
        kw_valid = 1'b0;
    endtask

    task automatic t_unmapped;
        rd_check("R11 hole 0x0C", 8'h0C, 32'h0);
        rd_check("R11 past bank", 8'h24, 32'h0);
        rd_check("R11 unaligned", 8'h11, 32'h0);
        wr_reg(8'h24, 32'hFFFF_FFFF);
        wr_reg(8'h11, 32'h0);
        wr_reg(8'h01, 32'h1);
        rd_check("R11 slot0 kept", 8'h10, 32'h3);
        rd_check("R11 slot3 kept", 8'h1C, 32'h3);
        rd_check("R11 ctrl kept", 8'h00, 32'h0);
        check("R11 eng_off", 32'(eng_off), 32'h0);
    endtask

    task automatic t_config;
        wr_reg(8'h04, 32'h2);
        #1;
        check("R9 act_slot", 32'(act_slot), 32'h2);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_check("R9 cfg masked", 8'h04, 32'h3);
        check("R9 act_slot max", 32'(act_slot), 32'h3);
        wr_reg(8'h08, 32'h1);
        rd_check("R9 ext set", 8'h08, 32'h1);
        check("R9 sched_off", 32'(sched_off), 32'h1);
        wr_reg(8'h08, 32'h0);
        #1;
        check("R9 sched_off clear", 32'(sched_off), 32'h0);
    endtask

    task automatic t_engine;
        @(negedge clk);
        start_req = 1'b1;
        #1;
        check("R8 start while enabled", 32'(core_start), 32'h1);
        start_req = 1'b0;
        wr_reg(8'h00, 32'h1);
        rd_check("R7 disabled", 8'h00, 32'h1);
        wr_reg(8'h00, 32'h0);
        rd_check("R7 zero write keeps", 8'h00, 32'h1);
        check("R7 eng_off", 32'(eng_off), 32'h1);
        @(negedge clk);
        start_req = 1'b1;
        #1;
        check("R8 start blocked", 32'(core_start), 32'h0);
        @(negedge clk);
        start_req = 1'b0;
        check("R8 err raised", 32'(err_flag), 32'h1);
        repeat (3) @(negedge clk);
        check("R8 err sticky", 32'(err_flag), 32'h1);
        rd_check("R8 ctrl err bit", 8'h00, 32'h3);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        kw_valid = 1'b0; kw_slot = '0; kw_word = '0; kw_data = '0;
        kr_slot = '0; ks_rd_data = '0; start_req = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_lock();
        t_update_lock();
        t_secure();
        t_invalid();
        t_unmapped();
        t_config();
        t_engine();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule